// File: doc/BRIEF.md
# Randomized Window Exponent Recoder

This block prepares an exponent for a windowed modular exponentiation whose precomputed table holds randomized powers rather than plain consecutive ones. A random offset `r` of `B` bits is taken away from the `K`-bit exponent at a series of window positions. The offset starts at `r` and moves `T` bits further left at each step. A step takes the offset away only if the working value is at least as large as the offset. When the pass is over, the low `B` bits of the working value form a small residual. The bits above them split into `T`-bit window digits, which the exponentiation stage reads one at a time through an indexed port.

A pulse on `start` loads the exponent and the offset. Each step spends one cycle on a magnitude compare. A step that takes the offset away then spends one more cycle per `W`-bit word, because the subtraction runs through an internal ripple datapath one word at a time. `done` pulses once when the last step is over. The residual, the digits and the per-window "offset applied" flags then stay readable until the next start.

Top module: `wexp_recoder`

## Requirements
- R1: After reset, `busy` and `done` are both 0.
- R2: The pass has NWIN = ceil((K-B)/T) steps, numbered j = 0 upwards. Step j compares the working value with r·2^(j·T) and subtracts it only when the working value is greater than or equal to it. The working value starts at the exponent.
- R3: When the pass is over, `rd_dm` equals bits [B-1:0] of the working value.
- R4: `rd_digit` for index j equals bits [B+j·T+T-1 : B+j·T] of the final working value, and bits at or above position K read as 0. `rd_applied` for index j is 1 exactly when step j subtracted.
- R5: The outputs satisfy exponent = Σ_j (digit_j·2^B + applied_j·r)·2^(j·T) + dm.
- R6: `done` is high in the cycle that follows clock edge e0+L, where e0 is the edge that accepts `start`. L = NWIN + NWORD·S, NWORD = ceil(K/W), and S is the number of steps that subtracted. `busy` is high from edge e0 up to edge e0+L.
- R7: `done` lasts exactly one cycle, and `busy` is low whenever `done` is high.
- R8: `start` is ignored while `busy` is high: the run in progress finishes with the result and timing of the exponent it first accepted.
- R9: While the block is idle and `start` is low, `rd_dm` and the digit outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a recoding run (taken only when idle) |
| exp_in | input | K | Exponent to recode |
| rnd_in | input | B | Random offset |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when a run completes |
| rd_dm | output | B | Residual low bits |
| rd_idx | input | IW | Window index to read (0 = least significant) |
| rd_digit | output | T | Window digit at `rd_idx` |
| rd_applied | output | 1 | Offset was subtracted at step `rd_idx` |

## Verification
The bound checker watches the control handshake on every cycle. It checks that `done` is a single-cycle pulse with `busy` low and that it always follows a busy period. It also checks that an idle `start` makes the block busy on the next edge and that the residual holds still while the block is idle. The bench brings out the arithmetic: the compare-and-subtract decisions, the digit slicing, the reconstruction identity, the exact latency, which depends on how many steps subtracted, and the way a start pulse sent mid-run is ignored. These can only be shown by running scenarios and comparing them with a behavioural model. The scenarios include an offset of zero, an exponent smaller than the offset, an all-ones exponent and random operands.

// File: rtl/wexp_recoder.sv
module wexp_recoder #(
  parameter  int K    = 32,
  parameter  int B    = 3,
  parameter  int T    = 2,
  parameter  int W    = 8,
  localparam int NWIN = (K - B + T - 1) / T,
  localparam int IW   = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [K-1:0]  exp_in,
  input  logic [B-1:0]  rnd_in,
  output logic          busy,
  output logic          done,
  output logic [B-1:0]  rd_dm,
  input  logic [IW-1:0] rd_idx,
  output logic [T-1:0]  rd_digit,
  output logic          rd_applied
);

  localparam int NWORD = (K + W - 1) / W;
  localparam int KP    = NWORD * W;
  localparam int SW    = B + NWIN * T;
  localparam int CW    = (SW > KP) ? SW : KP;
  localparam int WCW   = (NWORD > 1) ? $clog2(NWORD) : 1;

  typedef enum logic [1:0] {S_IDLE, S_CMP, S_SUB} state_t;

  state_t          state;
  logic [KP-1:0]   dw;
  logic [SW-1:0]   subt;
  logic [IW-1:0]   idx;
  logic [WCW-1:0]  wc;
  logic            carry;
  logic [NWIN-1:0] applied;

  logic [CW-1:0]   dw_ext;
  logic [CW-1:0]   subt_ext;
  logic [W-1:0]    dw_word;
  logic [W-1:0]    sb_word;
  logic [W:0]      word_sum;
  logic            ge;
  logic            last_step;
  logic            last_word;

  assign dw_ext    = CW'(dw);
  assign subt_ext  = CW'(subt);
  assign ge        = dw_ext >= subt_ext;
  assign last_step = idx == IW'(NWIN - 1);
  assign last_word = wc == WCW'(NWORD - 1);
  assign dw_word   = dw[int'(wc)*W +: W];
  assign sb_word   = subt_ext[int'(wc)*W +: W];
  assign word_sum  = {1'b0, dw_word} + {1'b0, ~sb_word} + {{W{1'b0}}, carry};

  assign busy  = state != S_IDLE;
  assign rd_dm = dw[B-1:0];

  always_comb begin
    rd_digit   = '0;
    rd_applied = 1'b0;
    if (int'(rd_idx) < NWIN) begin
      rd_digit   = dw_ext[B + int'(rd_idx)*T +: T];
      rd_applied = applied[rd_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      done    <= 1'b0;
      dw      <= '0;
      subt    <= '0;
      idx     <= '0;
      wc      <= '0;
      carry   <= 1'b0;
      applied <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            dw      <= KP'(exp_in);
            subt    <= SW'(rnd_in);
            idx     <= '0;
            applied <= '0;
            state   <= S_CMP;
          end
        end
        S_CMP: begin
          if (ge) begin
            applied[idx] <= 1'b1;
            wc           <= '0;
            carry        <= 1'b1;
            state        <= S_SUB;
          end else begin
            subt <= subt << T;
            if (last_step) begin
              done  <= 1'b1;
              state <= S_IDLE;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        S_SUB: begin
          dw[int'(wc)*W +: W] <= word_sum[W-1:0];
          carry               <= word_sum[W];
          if (last_word) begin
            subt <= subt << T;
            if (last_step) begin
              done  <= 1'b1;
              state <= S_IDLE;
            end else begin
              idx   <= idx + 1'b1;
              state <= S_CMP;
            end
          end else begin
            wc <= wc + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/wexp_recoder_chk.sv
module wexp_recoder_chk #(
  parameter int B = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [B-1:0] rd_dm
);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_done_after_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  p_start_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(rd_dm));

endmodule

bind wexp_recoder wexp_recoder_chk #(.B(B)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .busy  (busy),
  .done  (done),
  .rd_dm (rd_dm)
);

// File: tb/wexp_recoder_tb.sv
`timescale 1ns/100ps
module wexp_recoder_tb;
  localparam int K     = 32;
  localparam int B     = 3;
  localparam int T     = 2;
  localparam int W     = 8;
  localparam int NWIN  = (K - B + T - 1) / T;
  localparam int IW    = (NWIN > 1) ? $clog2(NWIN) : 1;
  localparam int NWORD = (K + W - 1) / W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [K-1:0]  exp_in = '0;
  logic [B-1:0]  rnd_in = '0;
  logic          busy, done;
  logic [B-1:0]  rd_dm;
  logic [IW-1:0] rd_idx = '0;
  logic [T-1:0]  rd_digit;
  logic          rd_applied;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  wexp_recoder #(.K(K), .B(B), .T(T), .W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .exp_in(exp_in), .rnd_in(rnd_in),
    .busy(busy), .done(done), .rd_dm(rd_dm), .rd_idx(rd_idx),
    .rd_digit(rd_digit), .rd_applied(rd_applied)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference of the recoding
  longint ref_dm;
  longint ref_dig [NWIN];
  bit     ref_app [NWIN];
  int     ref_len;

  task automatic compute_ref(input longint e, input longint r);
    longint d = e;
    longint s = r;
    int nsub = 0;
    for (int j = 0; j < NWIN; j++) begin
      ref_app[j] = 0;
      if (d >= s) begin
        d = d - s;
        ref_app[j] = 1;
        nsub++;
      end
      s = s << T;
    end
    ref_dm = d & ((64'd1 << B) - 1);
    for (int j = 0; j < NWIN; j++)
      ref_dig[j] = (d >> (B + j*T)) & ((64'd1 << T) - 1);
    ref_len = NWIN + NWORD * nsub;
  endtask

  // cycle-by-cycle control model
  int  next_len = 0;
  int  mcnt = 0;
  bit  mdone = 0;
  bit  model_on = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcnt = 0;
      mdone = 0;
    end else if (mcnt > 0) begin
      mcnt--;
      mdone = (mcnt == 0);
    end else begin
      mdone = 0;
      if (start) mcnt = next_len;
    end
  end

  always @(negedge clk) begin
    if (rst_n && model_on) begin
      chk(busy == (mcnt > 0), "R6 busy", busy, mcnt > 0);   // R6, R8
      chk(done == mdone, "R7 done", done, mdone);           // R7
    end
  end

  task automatic read_and_check(input longint e, input longint r, input string tag);
    longint rec = 0;
    longint dig;
    chk(rd_dm == B'(ref_dm), {"R3 dm ", tag}, rd_dm, ref_dm);
    for (int j = 0; j < NWIN; j++) begin
      rd_idx = IW'(j);
      #0.2;
      dig = rd_digit;
      chk(rd_digit == T'(ref_dig[j]), {"R4 digit ", tag}, rd_digit, ref_dig[j]);
      chk(rd_applied == ref_app[j], {"R2 applied ", tag}, rd_applied, ref_app[j]);
      rec = rec + (((dig << B) + (rd_applied ? r : 0)) << (j*T));
    end
    rec = rec + rd_dm;
    chk(rec == e, {"R5 identity ", tag}, rec, e);
  endtask

  task automatic run_one(input longint e, input longint r, input bit poke, input string tag);
    int waited = 0;
    compute_ref(e, r);
    next_len = ref_len;
    @(negedge clk);
    exp_in = K'(e);
    rnd_in = B'(r);
    start  = 1'b1;
    @(negedge clk);
    start  = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      exp_in = ~K'(e);
      rnd_in = ~B'(r);
      start  = 1'b1;          // R8: must be ignored while busy
      @(negedge clk);
      start  = 1'b0;
    end
    while (!done && waited < 4000) begin
      @(negedge clk);
      waited++;
    end
    read_and_check(e, r, tag);
    // R9: idle outputs hold
    @(negedge clk);
    @(negedge clk);
    chk(rd_dm == B'(ref_dm), {"R9 hold ", tag}, rd_dm, ref_dm);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy after release", busy, 0);
    chk(done == 1'b0, "R1 done after release", done, 0);
    model_on = 1;

    run_one(64'd0, 64'd5, 0, "zero exp");
    run_one(64'hFFFF_FFFF, 64'd7, 0, "all ones");
    run_one(64'd3, 64'd5, 0, "exp below offset");
    run_one(64'h1234_5678, 64'd0, 0, "zero offset");
    run_one(64'h8000_0000, 64'd1, 0, "top bit");
    run_one(64'hDEAD_BEEF, 64'd3, 1, "R8 start while busy");
    for (int n = 0; n < 30; n++) begin
      longint e = longint'($urandom());
      longint r = longint'($urandom_range(0, (1 << B) - 1));
      run_one(e, r, 0, "random");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule